// File: doc/BRIEF.md
# PDM Microphone Clock Generator and Lane Sampler

This block drives the clock pin of one or more pulse-density-modulated microphones from a single system clock and takes one bit from each data line per microphone-clock phase. The microphone clock comes from a counter that flips the pin after a fixed number of system cycles. The pin is an output only and never clocks any logic. A run input gates the whole block. While run is low the pin is held low and nothing is reported. When run goes high the pin starts with a full low half-period.

Each data pin passes through a two-flop synchroniser. A fixed number of system cycles after a microphone-clock transition, the block latches every synchronised lane. It then reports the latched bits one lane per cycle on a strobe, with the lane index and a slot index beside each bit. With two slots per line, two microphones share one wire: one drives data after the rising edge and the other after the falling edge. With one slot per line, only the rising-edge sample is used. Word packing, buffering and filtering belong to the logic downstream.

Top module: `pdm_capture_front`

## Requirements
- R1: While run is high and clear is low, the microphone clock pin changes level exactly once every HALF_CYC system cycles, which gives a period of 2*HALF_CYC cycles.
- R2: While run is low, the microphone clock pin is low and no strobe is produced. After run rises, the first rising edge of the pin comes exactly HALF_CYC cycles after the first clock edge that samples run high.
- R3: A one-cycle clear forces the pin low, drops every capture that is pending or still being reported, and restarts the divider: the next rising edge comes HALF_CYC + 1 cycles after the cycle in which clear is applied.
- R4: The reported bit of a lane is the level its pin held from the microphone-clock transition until SAMPLE_DLY cycles later. The first strobe of that capture is valid in the cycle that follows the SAMPLE_DLY-th clock edge after the transition.
- R5: With SLOTS = 2, a capture taken after a rising edge carries slot 0, and a capture taken after a falling edge carries slot 1.
- R6: With SLOTS = 1, only rising-edge transitions produce captures, and every strobe carries slot 0.
- R7: A capture is reported as LANES consecutive one-cycle strobes, with lane indices 0, 1, … LANES-1 in that order.
- R8: While reset is asserted, the microphone clock pin and the strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_i | input | 1 | High to generate the microphone clock and capture data |
| clr_i | input | 1 | Synchronous one-cycle clear of the divider, the delay timer and the reporting |
| mic_clk_o | output | 1 | Clock pin to the microphones |
| mic_dat_i | input | LANES | Raw 1-bit data pins, one per line |
| smp_valid_o | output | 1 | One-cycle strobe: a captured bit is presented |
| smp_bit_o | output | 1 | Captured data bit |
| smp_lane_o | output | LANE_W | Lane index of the bit |
| smp_slot_o | output | 1 | Slot index of the bit (0 = after rising edge, 1 = after falling edge) |

## Verification
A divider count that is off shows up on the pin within one half-period, as a change of level that comes early or late. A wrong delay-timer state moves the first strobe of a capture away from SAMPLE_DLY cycles after the transition. It can also latch the data of the neighbouring phase, and that shows in the bit within one capture. A serializer that skips or repeats a lane, or a slot flag that takes the wrong edge, shows in the lane and slot fields of the same capture. A clear or stop that leaves state behind gives a strobe that nothing expects, or a next rising edge that is off by cycles.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

  // index width with a floor of one bit
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    SLOT_RISE = 1'b0,
    SLOT_FALL = 1'b1
  } slot_e;

endpackage

// File: rtl/pdm_clk_divider.sv
module pdm_clk_divider
  import pdm_cap_pkg::*;
#(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic mic_clk_o,
  output logic tick_o,
  output logic rise_o
);

  localparam int unsigned CW = idx_width(HALF_CYC);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          active;

  assign active = run_i && !clr_i;
  assign tick_o = active && (cnt_q == LAST);
  assign rise_o = tick_o && !lvl_q;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!active) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (tick_o) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign mic_clk_o = lvl_q;

endmodule

// File: rtl/pdm_pin_sync.sv
module pdm_pin_sync #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end

endmodule

// File: rtl/pdm_sample_timer.sv
module pdm_sample_timer
  import pdm_cap_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 4,
  parameter int unsigned SLOTS     = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  logic  clr_i,
  input  logic  tick_i,
  input  logic  rise_i,
  output logic  fire_o,
  output slot_e slot_o
);

  localparam int unsigned DW = idx_width(DELAY_CYC);
  localparam logic [DW-1:0] LAST = DW'(DELAY_CYC - 1);

  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          armed_q, armed_d;
  slot_e         phase_q, phase_d;
  logic          active, due, keep;

  assign active = run_i && !clr_i;
  assign due    = armed_q && (dcnt_q == LAST);

  // variant: a single slot per line uses rising-edge captures only
  if (SLOTS > 1) begin : g_dual
    assign keep = 1'b1;
  end else begin : g_single
    assign keep = (phase_q == SLOT_RISE);
  end

  assign fire_o = active && due && keep;
  assign slot_o = phase_q;

  always_comb begin
    dcnt_d  = dcnt_q;
    armed_d = armed_q;
    phase_d = phase_q;
    if (!active) begin
      dcnt_d  = '0;
      armed_d = 1'b0;
      phase_d = SLOT_RISE;
    end else if (tick_i) begin
      dcnt_d  = '0;
      armed_d = 1'b1;
      phase_d = rise_i ? SLOT_RISE : SLOT_FALL;
    end else if (due) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      dcnt_d = dcnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      armed_q <= 1'b0;
      phase_q <= SLOT_RISE;
    end else begin
      dcnt_q  <= dcnt_d;
      armed_q <= armed_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/pdm_lane_serializer.sv
module pdm_lane_serializer
  import pdm_cap_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = idx_width(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [LANES-1:0]  bits_i,
  input  slot_e             slot_i,
  output logic              valid_o,
  output logic              bit_o,
  output logic [LANE_W-1:0] lane_o,
  output slot_e             slot_o
);

  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

  logic [LANES-1:0]  sh_q, sh_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              busy_q, busy_d;
  slot_e             slot_q, slot_d;

  always_comb begin
    sh_d   = sh_q;
    lane_d = lane_q;
    busy_d = busy_q;
    slot_d = slot_q;
    if (!run_i || clr_i) begin
      busy_d = 1'b0;
      lane_d = '0;
    end else if (load_i) begin
      sh_d   = bits_i;
      lane_d = '0;
      busy_d = 1'b1;
      slot_d = slot_i;
    end else if (busy_q) begin
      if (lane_q == LAST) begin
        busy_d = 1'b0;
      end else begin
        lane_d = lane_q + LANE_W'(1);
        sh_d   = sh_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      lane_q <= '0;
      busy_q <= 1'b0;
      slot_q <= SLOT_RISE;
    end else begin
      sh_q   <= sh_d;
      lane_q <= lane_d;
      busy_q <= busy_d;
      slot_q <= slot_d;
    end
  end

  assign valid_o = busy_q;
  assign bit_o   = sh_q[0];
  assign lane_o  = lane_q;
  assign slot_o  = slot_q;

endmodule

// File: rtl/pdm_capture_front.sv
module pdm_capture_front
  import pdm_cap_pkg::*;
#(
  parameter int unsigned LANES     = 2,
  parameter int unsigned SLOTS     = 2,
  parameter int unsigned HALF_CYC  = 8,
  parameter int unsigned SAMPLE_DLY = 4,
  localparam int unsigned LANE_W   = idx_width(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              clr_i,
  output logic              mic_clk_o,
  input  logic [LANES-1:0]  mic_dat_i,
  output logic              smp_valid_o,
  output logic              smp_bit_o,
  output logic [LANE_W-1:0] smp_lane_o,
  output logic              smp_slot_o
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic             tick, rise, fire;
  logic [LANES-1:0] dat_sync;
  slot_e            cap_slot, out_slot;

  pdm_clk_divider #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst_n(rst_q), .run_i(run_i), .clr_i(clr_i),
    .mic_clk_o(mic_clk_o), .tick_o(tick), .rise_o(rise)
  );

  pdm_pin_sync #(.LANES(LANES)) u_sync (
    .clk(clk), .rst_n(rst_q), .d_i(mic_dat_i), .q_o(dat_sync)
  );

  pdm_sample_timer #(.DELAY_CYC(SAMPLE_DLY), .SLOTS(SLOTS)) u_tmr (
    .clk(clk), .rst_n(rst_q), .run_i(run_i), .clr_i(clr_i),
    .tick_i(tick), .rise_i(rise), .fire_o(fire), .slot_o(cap_slot)
  );

  pdm_lane_serializer #(.LANES(LANES), .LANE_W(LANE_W)) u_ser (
    .clk(clk), .rst_n(rst_q), .run_i(run_i), .clr_i(clr_i),
    .load_i(fire), .bits_i(dat_sync), .slot_i(cap_slot),
    .valid_o(smp_valid_o), .bit_o(smp_bit_o), .lane_o(smp_lane_o),
    .slot_o(out_slot)
  );

  assign smp_slot_o = (out_slot == SLOT_FALL);

endmodule

// File: rtl/pdm_capture_front_chk.sv
module pdm_capture_front_chk #(
  parameter int unsigned HALF_CYC = 8,
  parameter int unsigned LANES    = 2,
  parameter int unsigned SLOTS    = 2,
  parameter int unsigned LANE_W   = 1
) (
  input logic              clk,
  input logic              rst_q,
  input logic              run_i,
  input logic              clr_i,
  input logic              mic_clk_o,
  input logic              smp_valid_o,
  input logic [LANE_W-1:0] smp_lane_o,
  input logic              smp_slot_o
);

  localparam int unsigned GW = $clog2(HALF_CYC + 1);

  logic          mic_d, run_d;
  logic [GW-1:0] gap_q;

  // cycles of running since the pin last changed
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mic_d <= 1'b0;
      run_d <= 1'b0;
      gap_q <= '0;
    end else begin
      mic_d <= mic_clk_o;
      run_d <= run_i && !clr_i;
      if (!(run_i && !clr_i))                  gap_q <= '0;
      else if (mic_clk_o != mic_d)             gap_q <= GW'(1);
      else if (gap_q != GW'(HALF_CYC))         gap_q <= gap_q + GW'(1);
    end
  end

  // R1
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (run_d && (mic_clk_o != mic_d)) |-> (gap_q == GW'(HALF_CYC)));

  // R1
  toggle_due_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (run_d && (gap_q == GW'(HALF_CYC))) |-> (mic_clk_o != mic_d));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !run_i |=> (!mic_clk_o && !smp_valid_o));

  // R3
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    clr_i |=> (!mic_clk_o && !smp_valid_o));

  // R7
  lane_first_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(smp_valid_o) |-> (smp_lane_o == '0));

  // R7
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (smp_valid_o && run_i && !clr_i && (smp_lane_o != LANE_W'(LANES - 1)))
      |=> (smp_valid_o && (smp_lane_o == $past(smp_lane_o) + LANE_W'(1))));

  // R5
  slot_phase_chk: assert property (@(posedge clk) disable iff (!rst_q)
    smp_valid_o |-> (smp_slot_o == !mic_clk_o));

  if (SLOTS == 1) begin : g_mono
    // R6
    mono_slot_chk: assert property (@(posedge clk) disable iff (!rst_q)
      smp_valid_o |-> !smp_slot_o);
  end

endmodule

bind pdm_capture_front pdm_capture_front_chk #(
  .HALF_CYC(HALF_CYC), .LANES(LANES), .SLOTS(SLOTS), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst_q(rst_q), .run_i(run_i), .clr_i(clr_i),
  .mic_clk_o(mic_clk_o), .smp_valid_o(smp_valid_o),
  .smp_lane_o(smp_lane_o), .smp_slot_o(smp_slot_o)
);

// File: tb/pdm_capture_front_tb.sv
module pdm_capture_front_tb;

  localparam int HALF = 8;
  localparam int DLY  = 4;
  localparam int NL   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic clr = 1'b0;
  logic [NL-1:0] dat = '0;
  logic [0:0] mono_dat = 1'b0;

  logic mic, vld, sbit, sslot;
  logic [1:0] slane;
  logic m_mic, m_vld, m_bit, m_slot;
  logic [0:0] m_lane;

  always #5 clk = ~clk;

  pdm_capture_front #(.LANES(NL), .SLOTS(2), .HALF_CYC(HALF), .SAMPLE_DLY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(clr), .mic_clk_o(mic),
    .mic_dat_i(dat), .smp_valid_o(vld), .smp_bit_o(sbit), .smp_lane_o(slane),
    .smp_slot_o(sslot)
  );

  pdm_capture_front #(.LANES(1), .SLOTS(1), .HALF_CYC(HALF), .SAMPLE_DLY(DLY)) u_mono (
    .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(clr), .mic_clk_o(m_mic),
    .mic_dat_i(mono_dat), .smp_valid_o(m_vld), .smp_bit_o(m_bit), .smp_lane_o(m_lane),
    .smp_slot_o(m_slot)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic run_s = 1'b0;
  logic clr_s = 1'b0;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    run_s <= run;
    clr_s <= clr;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- expectation model ----------------
  int q_cyc[$];
  int q_bit[$];
  int q_lane[$];
  int q_slot[$];
  logic [15:0] lfsr = 16'hACE1;
  logic mic_prev = 1'b0;
  logic mono_prev = 1'b0;
  int seen_valid = 0;
  int mono_seen = 0;
  bit mono_pend = 0;
  int mono_due = 0;
  int mono_exp = 0;

  always @(negedge clk) begin
    if (!run_s || clr_s) begin
      q_cyc.delete(); q_bit.delete(); q_lane.delete(); q_slot.delete();
      mono_pend = 0;
    end
    if ((mic != mic_prev) && run_s && !clr_s) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int k = 0; k < NL; k++) begin
        dat[k] = lfsr[k];
        q_cyc.push_back(cyc + DLY + k);
        q_bit.push_back(int'(lfsr[k]));
        q_lane.push_back(k);
        q_slot.push_back(mic ? 0 : 1);
      end
    end
    mic_prev = mic;
    if (vld) begin
      seen_valid++;
      if (q_cyc.size() == 0) begin
        chk(0, "R7", "unexpected strobe at cycle", cyc, -1);
      end else begin
        chk(cyc == q_cyc[0], "R4", "strobe cycle", cyc, q_cyc[0]);
        chk(int'(sbit) == q_bit[0], "R4", "sampled bit", int'(sbit), q_bit[0]);
        chk(int'(slane) == q_lane[0], "R7", "lane index", int'(slane), q_lane[0]);
        chk(int'(sslot) == q_slot[0], "R5", "slot index", int'(sslot), q_slot[0]);
        void'(q_cyc.pop_front()); void'(q_bit.pop_front());
        void'(q_lane.pop_front()); void'(q_slot.pop_front());
      end
    end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
      chk(0, "R4", "missing strobe due at cycle", cyc, q_cyc[0]);
      void'(q_cyc.pop_front()); void'(q_bit.pop_front());
      void'(q_lane.pop_front()); void'(q_slot.pop_front());
    end

    // single-slot instance: only rising edges capture
    if ((m_mic != mono_prev) && run_s && !clr_s) begin
      mono_dat[0] = lfsr[NL];
      if (m_mic) begin
        mono_pend = 1;
        mono_due  = cyc + DLY;
        mono_exp  = int'(lfsr[NL]);
      end
    end
    mono_prev = m_mic;
    if (m_vld) begin
      mono_seen++;
      chk(mono_pend, "R6", "strobe without rising edge", cyc, mono_due);
      chk(cyc == mono_due, "R6", "single-slot strobe cycle", cyc, mono_due);
      chk(int'(m_bit) == mono_exp && !m_slot && m_lane == 1'b0, "R6",
          "single-slot bit/slot", int'(m_bit), mono_exp);
      mono_pend = 0;
    end else if (mono_pend && cyc >= mono_due) begin
      chk(0, "R6", "missing single-slot strobe", cyc, mono_due);
      mono_pend = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic wait_edge(input bit want_high, output int at);
    logic lp;
    lp = mic;
    at = -1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (mic == want_high && lp != want_high) begin
        at = cyc;
        break;
      end
      lp = mic;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(mic == 1'b0, "R8", "pin in reset", int'(mic), 0);
    chk(vld == 1'b0 && m_vld == 1'b0, "R8", "strobe in reset", int'(vld), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(mic == 1'b0 && m_mic == 1'b0, "R2", "pin idle while stopped", int'(mic), 0);
    chk(seen_valid == 0, "R2", "strobes while stopped", seen_valid, 0);
  endtask

  task automatic t_start();
    int c0, r0, f0, r1;
    @(negedge clk);
    run = 1'b1;
    c0 = cyc;
    wait_edge(1'b1, r0);
    chk(r0 == c0 + HALF, "R2", "first rise after run", r0, c0 + HALF);
    wait_edge(1'b0, f0);
    chk(f0 - r0 == HALF, "R1", "high half length", f0 - r0, HALF);
    wait_edge(1'b1, r1);
    chk(r1 - f0 == HALF, "R1", "low half length", r1 - f0, HALF);
  endtask

  task automatic t_stream();
    int r, s0, m0;
    wait_edge(1'b1, r);
    s0 = seen_valid;
    m0 = mono_seen;
    for (int i = 0; i < 10; i++) wait_edge(1'b1, r);
    chk(seen_valid - s0 == 20 * NL, "R7", "strobes over ten periods", seen_valid - s0, 20 * NL);
    chk(mono_seen - m0 == 10, "R6", "single-slot strobes over ten periods", mono_seen - m0, 10);
  endtask

  task automatic t_clear();
    int r, c0, s0;
    wait_edge(1'b1, r);
    repeat (2) @(negedge clk);
    clr = 1'b1;
    c0 = cyc;
    @(negedge clk);
    clr = 1'b0;
    chk(mic == 1'b0, "R3", "pin after clear", int'(mic), 0);
    s0 = seen_valid;
    wait_edge(1'b1, r);
    chk(r == c0 + 1 + HALF, "R3", "rise after clear", r, c0 + 1 + HALF);
    chk(seen_valid == s0, "R3", "dropped capture after clear", seen_valid - s0, 0);
  endtask

  task automatic t_stop();
    int r, c1, s0;
    bit quiet;
    wait_edge(1'b1, r);
    @(negedge clk);
    run = 1'b0;
    s0 = seen_valid;
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mic || vld || m_mic || m_vld) quiet = 0;
    end
    chk(quiet, "R2", "pin low and no strobe while stopped", int'(quiet), 1);
    chk(seen_valid == s0, "R2", "strobes after stop", seen_valid - s0, 0);
    run = 1'b1;
    c1 = cyc;
    wait_edge(1'b1, r);
    chk(r == c1 + HALF, "R2", "fresh low half after restart", r, c1 + HALF);
    for (int i = 0; i < 3; i++) wait_edge(1'b1, r);
  endtask

  bit finished = 0;

  initial begin
    t_reset();
    t_start();
    t_stream();
    t_clear();
    t_stream();
    t_stop();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule